// File: doc/BRIEF.md
# Gated-Enable Serial Character Receiver

This block receives 8-bit asynchronous serial characters (one start bit, eight data bits sent least significant bit first, one stop bit) and places each one in a single-entry receive buffer. The serial line first passes through a synchronizer. A one-cycle oversampling tick, sixteen per bit period, paces the logic. A falling line starts a candidate start bit. The candidate is confirmed only if the line is still low half a bit later. Each later bit is sampled at its centre.

The enable input only takes effect between characters. If the receiver is idle when enable drops, it stops at once and ignores the line. If a character is arriving, the receiver finishes it, stores it, passes through a one-cycle completion state and only then stops. After a re-enable, an idle-line detector reports ten quiet bit periods. With the wake-on-idle option set, the receiver discards any character that completes before such a quiet period has been seen since the enable.

The buffer drives a valid/ready output. `rx_valid` is the received flag, and a read happens on any cycle where `rx_valid` and `rx_ready` are both high. The receiver has no back-pressure. If a new character completes while the buffer is still unread, the new character overwrites the old one and the overrun flag is set. A consumer that holds `rx_ready` low therefore loses data but never stalls reception.

Top module: `uart_rx_gate`

## Requirements
- R1: After reset, rx_valid, rx_busy, rx_ferr, rx_overrun, line_idle and rx_irq are all 0.
- R2: A frame of low start bit, eight data bits LSB first and a stop bit is stored in rx_data with rx_valid set to 1. A read (rx_valid and rx_ready high at a clock edge) clears rx_valid.
- R3: A candidate start bit is confirmed at the eighth tick after the low was first seen. A low pulse that has ended by then is ignored and produces no character.
- R4: While disabled, the serial input is ignored: no character is received, and rx_valid and rx_data keep their values.
- R5: Dropping rx_en during a character does not abort it. The character is stored, and the receiver is disabled afterwards.
- R6: rx_ferr is stored together with each character: 1 if the sampled stop bit was low, 0 if it was high.
- R7: If a character is stored while rx_valid is 1 and no read happens in the same cycle, rx_overrun becomes 1 and rx_data holds the newer character. A read clears rx_overrun. If the store and a read coincide, rx_valid stays 1, rx_data holds the new character and rx_overrun stays 0.
- R8: line_idle becomes 1 at the 160th consecutive tick with the line high while enabled (ten bit periods), and returns to 0 once the line is low. The count restarts when the receiver is disabled.
- R9: With wake_on_idle at 1, a character that completes before line_idle has been seen since the last enable is discarded, and a character that completes after that is stored.
- R10: rx_irq equals rx_valid AND irq_en.
- R11: rx_busy is 1 from the confirmed start bit until the stop bit has been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Receiver enable, honoured between characters |
| os_tick | input | 1 | One-cycle oversampling pulse, 16 per bit |
| wake_on_idle | input | 1 | Discard characters until an idle line is seen after enable |
| irq_en | input | 1 | Interrupt request enable |
| rx_valid | output | 1 | Buffer holds an unread character |
| rx_ready | input | 1 | Consumer accepts the buffered character |
| rx_data | output | 8 | Buffered character |
| rx_ferr | output | 1 | Framing error of the buffered character |
| rx_overrun | output | 1 | An unread character was overwritten |
| line_idle | output | 1 | Ten quiet bit periods seen since enable |
| rx_busy | output | 1 | Character reception in progress |
| rx_irq | output | 1 | Interrupt request |

## Verification
The buffer store and the consumer read can fall in the same clock cycle. The bench drives the oversampling tick itself, so it knows which tick samples the stop bit. A second character is sent while the first is still unread, and `rx_ready` is raised in exactly the cycle of the stop-sample tick. The expected result is that the old character is consumed, `rx_valid` stays high with the new byte, and `rx_overrun` stays low. A matching run without the read must raise `rx_overrun`.

// File: rtl/uart_rx_gate_pkg.sv
package uart_rx_gate_pkg;
  typedef enum logic [1:0] {
    RX_OFF  = 2'd0,
    RX_IDLE = 2'd1,
    RX_RECV = 2'd2,
    RX_IRQ  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/uart_rx_gate_sync.sv
module uart_rx_gate_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= RESET_VAL;
        else        pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RESET_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_gate_idle.sv
module uart_rx_gate_idle #(
  parameter int OSR       = 16,
  parameter int IDLE_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic rxs,
  output logic idle
);
  localparam int LIMIT = OSR * IDLE_BITS;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (clr || !rxs)                cnt <= '0;
    else if (tick && cnt != CW'(LIMIT))  cnt <= cnt + 1'b1;
  end

  assign idle = (cnt == CW'(LIMIT));

  assert_idle_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(tick) && $past(rxs));
  assert_idle_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !rxs) |=> !idle);
endmodule

// File: rtl/uart_rx_gate_core.sv
module uart_rx_gate_core
  import uart_rx_gate_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              rxs,
  input  logic              wake_mode,
  input  logic              line_idle,
  output rx_state_t         state,
  output logic              load,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_ferr
);
  localparam int HALF = OSR / 2;
  localparam int TW   = $clog2(OSR);
  localparam int BW   = $clog2(DATA_W + 1);

  logic [TW-1:0]     tcnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] shreg;
  logic              hunting;
  logic              synced;
  logic              done;
  logic              bit_edge;

  assign bit_edge = tick && (tcnt == TW'(OSR - 1));
  assign done     = (state == RX_RECV) && bit_edge && (bidx == BW'(DATA_W));
  assign load     = done && (!wake_mode || synced);
  assign ld_data  = shreg;
  assign ld_ferr  = !rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) synced <= 1'b0;
    else if (state == RX_OFF) synced <= 1'b0;
    else if (line_idle) synced <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_OFF;
      tcnt    <= '0;
      bidx    <= '0;
      shreg   <= '0;
      hunting <= 1'b0;
    end else begin
      unique case (state)
        RX_OFF: begin
          hunting <= 1'b0;
          if (en) state <= RX_IDLE;
        end
        RX_IDLE: begin
          if (!en) begin
            state   <= RX_OFF;
            hunting <= 1'b0;
          end else if (tick) begin
            if (!hunting) begin
              if (!rxs) begin
                hunting <= 1'b1;
                tcnt    <= '0;
              end
            end else if (tcnt == TW'(HALF - 1)) begin
              hunting <= 1'b0;
              tcnt    <= '0;
              if (!rxs) begin
                state <= RX_RECV;
                bidx  <= '0;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RX_RECV: begin
          if (tick) begin
            if (bit_edge) begin
              tcnt <= '0;
              if (bidx == BW'(DATA_W)) begin
                state <= RX_IRQ;
              end else begin
                shreg <= {rxs, shreg[DATA_W-1:1]};
                bidx  <= bidx + 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RX_IRQ: begin
          state <= en ? RX_IDLE : RX_OFF;
        end
        default: state <= RX_OFF;
      endcase
    end
  end

  assert_off_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_OFF && !en) |=> (state == RX_OFF));
  assert_no_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_RECV && !en && !done) |=> (state == RX_RECV));
  assert_load_in_recv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (state == RX_RECV));
  assert_exit_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IRQ && !en) |=> (state == RX_OFF));
endmodule

// File: rtl/uart_rx_gate_buf.sv
module uart_rx_gate_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_ferr,
  input  logic              rd_ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              ferr,
  output logic              overrun
);
  logic rd;
  assign rd = valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      ferr    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (load) begin
        data <= ld_data;
        ferr <= ld_ferr;
      end
      if (load)    valid <= 1'b1;
      else if (rd) valid <= 1'b0;
      if (load && valid && !rd) overrun <= 1'b1;
      else if (rd)              overrun <= 1'b0;
    end
  end

  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && valid && !rd_ready) |=> overrun);
  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rd_ready && !load) |=> !valid);
  assert_data_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(data) && $stable(ferr));
endmodule

// File: rtl/uart_rx_gate.sv
module uart_rx_gate
  import uart_rx_gate_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int IDLE_BITS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              rx_en,
  input  logic              os_tick,
  input  logic              wake_on_idle,
  input  logic              irq_en,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              rx_overrun,
  output logic              line_idle,
  output logic              rx_busy,
  output logic              rx_irq
);
  logic              rxs;
  rx_state_t         state;
  logic              load;
  logic [DATA_W-1:0] ld_data;
  logic              ld_ferr;

  uart_rx_gate_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_in), .q(rxs)
  );

  uart_rx_gate_idle #(.OSR(OSR), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(state == RX_OFF), .tick(os_tick),
    .rxs(rxs), .idle(line_idle)
  );

  uart_rx_gate_core #(.DATA_W(DATA_W), .OSR(OSR)) u_core (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .rxs(rxs),
    .wake_mode(wake_on_idle), .line_idle(line_idle), .state(state),
    .load(load), .ld_data(ld_data), .ld_ferr(ld_ferr)
  );

  uart_rx_gate_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_data(ld_data),
    .ld_ferr(ld_ferr), .rd_ready(rx_ready), .valid(rx_valid),
    .data(rx_data), .ferr(rx_ferr), .overrun(rx_overrun)
  );

  assign rx_busy = (state == RX_RECV);
  assign rx_irq  = rx_valid && irq_en;

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> $past(state) == RX_IDLE);
endmodule

// File: tb/uart_rx_gate_tb.sv
module uart_rx_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic rx_en = 1'b0;
  logic os_tick = 1'b0;
  logic wake_on_idle = 1'b0;
  logic irq_en = 1'b0;
  logic rx_ready = 1'b0;
  logic rx_valid, rx_ferr, rx_overrun, line_idle, rx_busy, rx_irq;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic busy_mid;

  always #2 clk = ~clk;

  uart_rx_gate u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_en(rx_en),
    .os_tick(os_tick), .wake_on_idle(wake_on_idle), .irq_en(irq_en),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .rx_overrun(rx_overrun), .line_idle(line_idle),
    .rx_busy(rx_busy), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick1(input logic rd);
    repeat (3) @(negedge clk);
    os_tick  = 1'b1;
    rx_ready = rd;
    @(negedge clk);
    os_tick  = 1'b0;
    rx_ready = 1'b0;
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) tick1(1'b0);
  endtask

  task automatic do_read();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop_b,
                            input int rd_at, input int drop_at);
    busy_mid = 1'b0;
    for (int b = 0; b < 10; b++) begin
      rx_in = (b == 0) ? 1'b0 : (b == 9) ? stop_b : d[b-1];
      for (int t = 0; t < 16; t++) begin
        if (b * 16 + t == drop_at) rx_en = 1'b0;
        tick1(b * 16 + t == rd_at);
        if (b * 16 + t == 100) busy_mid = rx_busy;
      end
    end
    rx_in = 1'b1;
    idle_ticks(20);
  endtask

  task automatic t_reset();
    chk("R1 valid", rx_valid, 0);
    chk("R1 busy", rx_busy, 0);
    chk("R1 ferr", rx_ferr, 0);
    chk("R1 overrun", rx_overrun, 0);
    chk("R1 idle", line_idle, 0);
    chk("R1 irq", rx_irq, 0);
  endtask

  task automatic t_basic();
    rx_en = 1'b1; irq_en = 1'b1;
    idle_ticks(5);
    send_frame(8'hA5, 1'b1, -1, -1);
    chk("R11 busy mid-frame", busy_mid, 1);
    chk("R11 busy after", rx_busy, 0);
    chk("R2 valid", rx_valid, 1);
    chk("R2 data", rx_data, 8'hA5);
    chk("R6 ferr clear", rx_ferr, 0);
    chk("R10 irq on", rx_irq, 1);
    irq_en = 1'b0; @(negedge clk);
    chk("R10 irq masked", rx_irq, 0);
    do_read();
    chk("R2 read clears", rx_valid, 0);
    send_frame(8'h01, 1'b1, -1, -1);
    chk("R2 lsb first", rx_data, 8'h01);
    do_read();
  endtask

  task automatic t_glitch();
    rx_in = 1'b0;
    idle_ticks(4);
    rx_in = 1'b1;
    idle_ticks(200);
    chk("R3 glitch no char", rx_valid, 0);
    chk("R3 glitch not busy", rx_busy, 0);
  endtask

  task automatic t_ferr();
    send_frame(8'h3C, 1'b0, -1, -1);
    chk("R6 ferr data", rx_data, 8'h3C);
    chk("R6 ferr set", rx_ferr, 1);
    do_read();
    send_frame(8'h5A, 1'b1, -1, -1);
    chk("R6 ferr cleared", rx_ferr, 0);
    do_read();
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 1'b1, -1, -1);
    send_frame(8'h22, 1'b1, -1, -1);
    chk("R7 overrun set", rx_overrun, 1);
    chk("R7 newest data", rx_data, 8'h22);
    do_read();
    chk("R7 read clears overrun", rx_overrun, 0);
    chk("R7 read clears valid", rx_valid, 0);
  endtask

  task automatic t_same_cycle();
    send_frame(8'h33, 1'b1, -1, -1);
    send_frame(8'h44, 1'b1, 152, -1);
    chk("R7 same-cycle valid", rx_valid, 1);
    chk("R7 same-cycle data", rx_data, 8'h44);
    chk("R7 same-cycle no overrun", rx_overrun, 0);
    do_read();
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    idle_ticks(2);
    send_frame(8'h55, 1'b1, -1, -1);
    chk("R4 ignored valid", rx_valid, 0);
    chk("R4 data held", rx_data, 8'h44);
    chk("R4 not busy", busy_mid, 0);
  endtask

  task automatic t_disable_mid();
    rx_en = 1'b1;
    idle_ticks(5);
    send_frame(8'h66, 1'b1, -1, 50);
    chk("R5 busy continues", busy_mid, 1);
    chk("R5 char stored", rx_valid, 1);
    chk("R5 char data", rx_data, 8'h66);
    send_frame(8'h77, 1'b1, -1, -1);
    chk("R5 stopped after char", rx_data, 8'h66);
    chk("R5 no overrun after stop", rx_overrun, 0);
    do_read();
  endtask

  task automatic t_idle_line();
    rx_en = 1'b0;
    tick1(1'b0);
    rx_en = 1'b1;
    idle_ticks(159);
    chk("R8 idle before limit", line_idle, 0);
    idle_ticks(1);
    chk("R8 idle at limit", line_idle, 1);
    rx_in = 1'b0;
    tick1(1'b0);
    chk("R8 idle cleared by low", line_idle, 0);
    rx_in = 1'b1;
    idle_ticks(30);
  endtask

  task automatic t_wake();
    wake_on_idle = 1'b1;
    rx_en = 1'b0;
    tick1(1'b0);
    rx_en = 1'b1;
    idle_ticks(10);
    send_frame(8'h81, 1'b1, -1, -1);
    chk("R9 early char dropped", rx_valid, 0);
    idle_ticks(170);
    send_frame(8'h82, 1'b1, -1, -1);
    chk("R9 char after idle", rx_valid, 1);
    chk("R9 data after idle", rx_data, 8'h82);
    do_read();
    wake_on_idle = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 200000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 200000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_glitch();
    t_ferr();
    t_overrun();
    t_same_cycle();
    t_disabled();
    t_disable_mid();
    t_idle_line();
    t_wake();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule